// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Controller

This block raises and clears port-to-port interrupts for a two-port shared memory. Both ports reach the same memory, and the two topmost word addresses are kept as mailboxes. The all-ones address belongs to the right port. The address just below it belongs to the left port. When one port writes into the mailbox of the other port, the owner of that mailbox gets an interrupt. The owner clears the interrupt by reading its own mailbox. The message itself is user defined and sits in the ordinary memory array, so this block never sees data. It sees only the enable, direction, address and busy inputs of each port.

The block samples every enabled port cycle on the rising clock edge. Each interrupt is held by a small state machine with two states. `IRQ_IDLE` drives the active-low output high. `IRQ_PENDING` drives it low. There are three transitions:
- SET moves a machine from IDLE to PENDING.
- CLEAR moves it from PENDING back to IDLE.
- HOLD keeps the current state.

When SET and CLEAR reach the same machine in one cycle, SET wins. A port whose busy input is active is treated as having lost arbitration. Its access can neither raise the peer's interrupt nor clear its own.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While reset is asserted, and on the first sampled cycle after it, both `lp_irq_n` and `rp_irq_n` are 1 (inactive).
- R2: A left-port write (`lp_sel`=1, `lp_wr`=1, `lp_busy`=0) to address 2^AW-1 drives `rp_irq_n` to 0 after that clock edge.
- R3: A right-port write (`rp_sel`=1, `rp_wr`=1, `rp_busy`=0) to address 2^AW-2 drives `lp_irq_n` to 0 after that clock edge.
- R4: A read (`*_wr`=0, `*_busy`=0) by a port of its own mailbox drives that port's interrupt output back to 1 after the edge. The left mailbox is 2^AW-2 and the right mailbox is 2^AW-1.
- R5: None of these change either interrupt output:
  - a read of the opposite port's mailbox;
  - a write to a port's own mailbox;
  - any access to an address below 2^AW-2.
- R6: A write to the peer's mailbox while the writer's busy input is 1 does not set the peer's interrupt.
- R7: A read of a port's own mailbox while that port's busy input is 1 does not clear its interrupt.
- R8: If the same interrupt receives a set and a clear in one cycle, it ends that cycle pending (output 0).
- R9: When a port's `*_sel` is 0, its other inputs have no effect on either interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_sel | input | 1 | Left port access enable, active high |
| lp_wr | input | 1 | Left port direction, 1 = write, 0 = read |
| lp_addr | input | AW | Left port word address |
| lp_busy | input | 1 | Left port lost arbitration, active high |
| rp_sel | input | 1 | Right port access enable, active high |
| rp_wr | input | 1 | Right port direction, 1 = write, 0 = read |
| rp_addr | input | AW | Right port word address |
| rp_busy | input | 1 | Right port lost arbitration, active high |
| lp_irq_n | output | 1 | Left port interrupt, active low |
| rp_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Directed sequences walk each transition separately:
- SET from each side;
- CLEAR by each owner;
- reads of the wrong mailbox;
- writes to a port's own mailbox;
- busy vetoes on both set and clear;
- a set colliding with a clear in one cycle.

These separate a swapped mailbox decode, from a clear that ignores ownership, from a busy that only blocks one of the two actions. Constrained-random traffic then biases addresses toward the two mailboxes, and it randomizes enable, direction and busy on both ports at once. This exercises simultaneous accesses from both ports that directed tests do not enumerate. It also catches wrong priority between set and clear. Every cycle is compared against a bench model of the two interrupts.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned LEFT_IDX  = 0;
    localparam int unsigned RIGHT_IDX = 1;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
    parameter int unsigned AW         = 12,
    parameter bit          OWN_IS_TOP = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic          busy,
    output logic          set_peer,
    output logic          clr_own
);
    localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
    localparam logic [AW-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;
    localparam logic [AW-1:0] OWN_ADDR  = OWN_IS_TOP ? TOP_ADDR  : NEXT_ADDR;
    localparam logic [AW-1:0] PEER_ADDR = OWN_IS_TOP ? NEXT_ADDR : TOP_ADDR;

    logic granted;
    logic hit_own;
    logic hit_peer;

    always_comb begin
        granted  = sel && !busy;
        hit_own  = (addr == OWN_ADDR);
        hit_peer = (addr == PEER_ADDR);
        set_peer = granted &&  wr && hit_peer;
        clr_own  = granted && !wr && hit_own;
    end

    // Busy must veto both kinds of request (R6, R7).
    p_busy_veto_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !set_peer && !clr_own);

    // A deselected port raises no request at all (R9).
    p_idle_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !set_peer && !clr_own);

    // A read never sets and a write never clears (R5).
    p_dir_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_peer && clr_own));
endmodule

// File: rtl/mbox_irq_fsm.sv
module mbox_irq_fsm
    import mbox_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (set_req) state_d = IRQ_PENDING;
            end
            IRQ_PENDING: begin
                if (clr_req && !set_req) state_d = IRQ_IDLE;
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_PENDING: irq_n = 1'b0;
            default:     irq_n = 1'b1;
        endcase
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> irq_n);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> !irq_n);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> irq_n);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_req && !clr_req) |=> $stable(irq_n));
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
    import mbox_irq_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lp_sel,
    input  logic          lp_wr,
    input  logic [AW-1:0] lp_addr,
    input  logic          lp_busy,
    input  logic          rp_sel,
    input  logic          rp_wr,
    input  logic [AW-1:0] rp_addr,
    input  logic          rp_busy,
    output logic          lp_irq_n,
    output logic          rp_irq_n
);
    logic [NUM_PORTS-1:0]         sel_v;
    logic [NUM_PORTS-1:0]         wr_v;
    logic [NUM_PORTS-1:0]         busy_v;
    logic [NUM_PORTS-1:0][AW-1:0] addr_v;
    logic [NUM_PORTS-1:0]         set_peer_v;
    logic [NUM_PORTS-1:0]         clr_own_v;
    logic [NUM_PORTS-1:0]         irq_n_v;

    always_comb begin
        sel_v[LEFT_IDX]   = lp_sel;
        wr_v[LEFT_IDX]    = lp_wr;
        busy_v[LEFT_IDX]  = lp_busy;
        addr_v[LEFT_IDX]  = lp_addr;
        sel_v[RIGHT_IDX]  = rp_sel;
        wr_v[RIGHT_IDX]   = rp_wr;
        busy_v[RIGHT_IDX] = rp_busy;
        addr_v[RIGHT_IDX] = rp_addr;
        lp_irq_n          = irq_n_v[LEFT_IDX];
        rp_irq_n          = irq_n_v[RIGHT_IDX];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mbox_port_decode #(
            .AW        (AW),
            .OWN_IS_TOP(p == RIGHT_IDX)
        ) u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel_v[p]),
            .wr      (wr_v[p]),
            .addr    (addr_v[p]),
            .busy    (busy_v[p]),
            .set_peer(set_peer_v[p]),
            .clr_own (clr_own_v[p])
        );

        mbox_irq_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_req(set_peer_v[NUM_PORTS-1-p]),
            .clr_req(clr_own_v[p]),
            .irq_n  (irq_n_v[p])
        );
    end

    // A write to the right mailbox by an unblocked left port raises the right interrupt (R2).
    p_left_sets_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_sel && lp_wr && !lp_busy && lp_addr == {AW{1'b1}}) |=> !rp_irq_n);

    // A write to the left mailbox by an unblocked right port raises the left interrupt (R3).
    p_right_sets_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_sel && rp_wr && !rp_busy && rp_addr == {AW{1'b1}} - 1'b1) |=> !lp_irq_n);
endmodule

// File: tb/mbox_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mbox_irq_ctrl_tb_top;
    localparam int unsigned AW = 12;
    localparam logic [AW-1:0] RMB = {AW{1'b1}};
    localparam logic [AW-1:0] LMB = {AW{1'b1}} - 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_sel = 1'b0, lp_wr = 1'b0, lp_busy = 1'b0;
    logic rp_sel = 1'b0, rp_wr = 1'b0, rp_busy = 1'b0;
    logic [AW-1:0] lp_addr = '0, rp_addr = '0;
    logic lp_irq_n, rp_irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit exp_l = 1'b0;
    bit exp_r = 1'b0;

    always #4 clk = ~clk;

    mbox_irq_ctrl #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lp_sel(lp_sel), .lp_wr(lp_wr), .lp_addr(lp_addr), .lp_busy(lp_busy),
        .rp_sel(rp_sel), .rp_wr(rp_wr), .rp_addr(rp_addr), .rp_busy(rp_busy),
        .lp_irq_n(lp_irq_n), .rp_irq_n(rp_irq_n)
    );

    function automatic bit next_pending(bit cur, bit set, bit clr);
        if (set) return 1'b1;
        if (clr) return 1'b0;
        return cur;
    endfunction

    function automatic bit wants(bit sel, bit busy, bit wr, bit want_wr,
                                 logic [AW-1:0] addr, logic [AW-1:0] target);
        return sel && !busy && (wr == want_wr) && (addr == target);
    endfunction

    task automatic check(bit got, bit exp, string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic step(bit ls, bit lw, logic [AW-1:0] la, bit lb,
                        bit rs, bit rw, logic [AW-1:0] ra, bit rb, string tag);
        bit set_r, set_l, clr_l, clr_r;
        lp_sel = ls; lp_wr = lw; lp_addr = la; lp_busy = lb;
        rp_sel = rs; rp_wr = rw; rp_addr = ra; rp_busy = rb;
        set_r = wants(ls, lb, lw, 1'b1, la, RMB);
        clr_l = wants(ls, lb, lw, 1'b0, la, LMB);
        set_l = wants(rs, rb, rw, 1'b1, ra, LMB);
        clr_r = wants(rs, rb, rw, 1'b0, ra, RMB);
        exp_l = next_pending(exp_l, set_l, clr_l);
        exp_r = next_pending(exp_r, set_r, clr_r);
        @(posedge clk);
        @(negedge clk);
        check(lp_irq_n, !exp_l, {tag, " left"});
        check(rp_irq_n, !exp_r, {tag, " right"});
    endtask

    function automatic logic [AW-1:0] pick_addr(int unsigned r);
        case (r % 4)
            0: return RMB;
            1: return LMB;
            2: return RMB - 2;
            default: return AW'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        checks++; if (lp_irq_n !== 1'b1) begin errors++; $display("FAIL R1: lp_irq_n=%0b expected=1", lp_irq_n); end
        checks++; if (rp_irq_n !== 1'b1) begin errors++; $display("FAIL R1: rp_irq_n=%0b expected=1", rp_irq_n); end
        rst_n = 1'b1;
        step(0,0,'0,0, 0,0,'0,0, "R1 after reset");
        // R2 / R4: left notifies right, right clears
        step(1,1,RMB,0, 0,0,'0,0, "R2 set right");
        step(1,0,RMB,0, 0,0,'0,0, "R5 left reads right mailbox");
        step(0,0,'0,0, 1,1,RMB,0, "R5 right writes own mailbox");
        step(0,0,'0,0, 1,0,RMB,1, "R7 busy blocks right clear");
        step(0,0,'0,0, 1,0,RMB,0, "R4 right clears");
        // R3 / R4 for left
        step(0,0,'0,0, 1,1,LMB,1, "R6 busy blocks left set");
        step(0,0,'0,0, 1,1,LMB,0, "R3 set left");
        step(0,0,'0,0, 1,0,LMB,0, "R5 right reads left mailbox");
        step(1,1,LMB,0, 1,1,RMB-2,0, "R5 own write and plain address");
        step(0,0,LMB,0, 0,1,RMB,0, "R9 deselected ports");
        step(1,0,LMB,1, 0,0,'0,0, "R7 busy blocks left clear");
        // R8: left clears while right sets in the same cycle
        step(1,0,LMB,0, 1,1,LMB,0, "R8 set beats clear");
        step(1,0,LMB,0, 0,0,'0,0, "R4 left clears");
        step(1,1,RMB,1, 0,0,'0,0, "R6 busy blocks right set");
        for (int i = 0; i < 400; i++) begin
            int unsigned r = $urandom;
            step(r[0], r[1], pick_addr($urandom), (r[4:2] == 0),
                 r[5], r[6], pick_addr($urandom), (r[9:7] == 0), "R5 random mix");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule